// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block lets a processor reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO pair. Software sees a single 32-bit command/status word. Writing that word starts one management frame. The frame is a read when the operation bit is 1 and a write when it is 0. The same word then shows a busy flag, a read-valid flag and, once a read has finished, the 16-bit result.

The expected driver sequence has four steps: wait for busy to drop, write the command, wait for busy to drop again, then read the word back. It reads back the result only when read-valid is set. MDC is made from the system clock by a divider of `MDC_HALF_DIV` system clocks per half period. It toggles only while a frame is in flight. The master changes MDIO after each falling MDC edge and samples it on each rising edge. It releases the line for the turnaround and data phases of a read.

Top module: `mdio_c22_master`

## Requirements
- R1: The command/status word reads back as: bits 15:0 data, bits 20:16 PHY address, bits 25:21 register address, bit 26 operation (1 = read, 0 = write), bit 27 read-valid, bit 28 busy, bits 31:29 zero. After reset the whole word reads 0.
- R2: A write to the word while busy is 0 is accepted. From the next cycle busy reads 1 and read-valid reads 0.
- R3: A write to the word while busy is 1 is ignored. It starts no second frame and leaves the PHY address, register address and operation fields unchanged.
- R4: A write command sends exactly 64 MDC cycles. The bits are, MSB first: 32 ones, start `01`, opcode `01`, the 5-bit PHY address, the 5-bit register address, turnaround `10`, and the 16 data bits.
- R5: A read command drives the first 46 bits: 32 ones, `01`, opcode `10`, the PHY address and the register address. It does not drive MDIO (enable low) for the remaining 18 bits.
- R6: A read samples MDIO on rising MDC edges. When busy falls, read-valid is 1 and bits 15:0 hold the 16 sampled data bits, first received in bit 15. This holds when the PHY drove the second turnaround bit (bit 47 of the frame) low.
- R7: If MDIO is high at the second turnaround bit of a read, read-valid stays 0 after busy falls.
- R8: MDC and the MDIO output enable are low whenever busy is 0. While busy, MDC has a period of 2×`MDC_HALF_DIV` system clocks.
- R9: Busy returns to 0 after the frame ends. A write command finishes with read-valid 0, and its data field still shows the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by software |
| reg_rdata | output | 32 | Command/status word as read back |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable, high to drive |

## Verification
The bench models a PHY on the MDIO line. It records every bit at rising MDC and answers reads after falling MDC, so any off-by-one in the bit counter or in the turnaround position shows up as a shifted frame or shifted read data. A second command issued in the middle of a frame would, on a design that ignored the busy lock, restart or corrupt the frame and change the reported address. A turnaround bit held high by the PHY must leave read-valid clear; a design that never checks it would report garbage as good data. A write issued after a good read must drop read-valid at once, or software could mistake stale data for a fresh result.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS    = 64;
    localparam int RD_DRIVE_BITS = 46;  // bits the master drives during a read
    localparam int TA_LOW_IDX    = 47;  // second turnaround bit, PHY drives 0
    localparam int DATA_IDX      = 48;  // first data bit of the frame
    localparam int WORD_W        = 32;
    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 5;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] regad;
        logic [ADDR_W-1:0] phy;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    function automatic mdio_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        mdio_cmd_t c;
        c.data    = w[15:0];
        c.phy     = w[20:16];
        c.regad   = w[25:21];
        c.is_read = w[26];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input mdio_cmd_t c,
                                                      input logic valid,
                                                      input logic busy);
        return {3'b000, busy, valid, c.is_read, c.regad, c.phy, c.data};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]        op;
        logic [DATA_W-1:0] payload;
        op      = c.is_read ? 2'b10 : 2'b01;
        payload = c.is_read ? {DATA_W{1'b1}} : c.data;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = en && (cnt == LAST);
    assign rise_now = wrap && !mdc;
    assign fall_now = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_now,
    input  logic              fall_now,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              ta_ok,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX  = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] DRV_LIMIT = IW'(RD_DRIVE_BITS);
    localparam logic [IW-1:0] TA_IDX    = IW'(TA_LOW_IDX);
    localparam logic [IW-1:0] D_IDX     = IW'(DATA_IDX);

    eng_state_t            state;
    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         idx;
    logic                  is_rd;

    assign active  = (state == ENG_SHIFT);
    assign mdio_o  = active && shreg[FRAME_BITS-1];
    assign mdio_oe = active && (!is_rd || (idx < DRV_LIMIT));

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state   <= ENG_IDLE;
            shreg   <= '0;
            idx     <= '0;
            is_rd   <= 1'b0;
            ta_ok   <= 1'b0;
            rd_data <= '0;
        end else if (state == ENG_IDLE) begin
            if (start) begin
                shreg <= build_frame(cmd);
                idx   <= '0;
                is_rd <= cmd.is_read;
                ta_ok <= 1'b0;
                state <= ENG_SHIFT;
            end
        end else begin
            if (rise_now) begin
                if (idx == TA_IDX)
                    ta_ok <= !mdio_i;
                if (idx >= D_IDX)
                    rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            end
            if (fall_now) begin
                shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                if (idx == LAST_IDX) begin
                    state <= ENG_IDLE;
                    done  <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    mdio_cmd_t         cmd_q;
    mdio_cmd_t         cmd_new;
    logic              busy_q;
    logic              valid_q;
    logic              accept;
    logic              eng_active;
    logic              eng_done;
    logic              eng_ta_ok;
    logic [DATA_W-1:0] eng_rd;
    logic              rise_now;
    logic              fall_now;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[31:27];
    assign cmd_new   = unpack_cmd(reg_wdata);
    assign accept    = reg_wr && !busy_q;
    assign reg_rdata = pack_status(cmd_q, valid_q, busy_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (accept) begin
            cmd_q   <= cmd_new;
            busy_q  <= 1'b1;
            valid_q <= 1'b0;
        end else if (eng_done) begin
            busy_q <= 1'b0;
            if (cmd_q.is_read && eng_ta_ok) begin
                valid_q    <= 1'b1;
                cmd_q.data <= eng_rd;
            end
        end
    end

    mdc_tick_gen #(
        .HALF_DIV (MDC_HALF_DIV)
    ) u_clkdiv (
        .clk      (clk),
        .rst      (rst),
        .en       (eng_active),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .cmd      (cmd_new),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .mdio_i   (mdio_i),
        .active   (eng_active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .ta_ok    (eng_ta_ok),
        .rd_data  (eng_rd)
    );
endmodule

// File: rtl/mdio_c22_master_chk.sv
module mdio_c22_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_oe
);
    logic busy;
    logic valid;
    assign busy  = reg_rdata[28];
    assign valid = reg_rdata[27];

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R8
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R8
    AST_VALID_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        valid |-> !busy); // R6
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !busy) |=> (busy && !valid)); // R2
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && busy) |=> $stable(reg_rdata[26:16])); // R3
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !reg_rdata[26]) |-> !valid); // R9
endmodule

bind mdio_c22_master mdio_c22_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_c22_master.sv
`timescale 1ns/1ps
module sim_mdio_c22_master;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // PHY model state
    logic        phy_drv = 1'b1;
    logic        ta_drv  = 1'b0;
    logic [15:0] resp    = '0;
    logic [63:0] seen    = '0;
    int rise_n = 0;
    int fall_n = 0;
    int oe_cnt = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_c22_master #(.MDC_HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always @(posedge mdc) begin
        if (rise_n < 64) seen[63 - rise_n] = mdio_i;
        if (mdio_oe) oe_cnt++;
        rise_n++;
    end

    always @(negedge mdc) begin
        fall_n++;
        if (fall_n == 47) phy_drv = ta_drv;
        else if (fall_n >= 48 && fall_n < 64) phy_drv = resp[63 - fall_n];
        else phy_drv = 1'b1;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {5'b0, rd, ra, phy, d};
    endfunction

    task automatic clear_phy();
        rise_n = 0; fall_n = 0; oe_cnt = 0; seen = '0; phy_drv = 1'b1;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (reg_rdata[28] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, "R9 busy timeout", 64'(n), 64'd5000);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == 32'h0, "R1 reset word", 64'(reg_rdata), 64'h0);
        check(!mdc && !mdio_oe, "R8 idle pins after reset", {mdc, mdio_oe}, 64'h0);
    endtask

    task automatic t_write();
        logic [63:0] exp;
        realtime t0, t1;
        clear_phy();
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h04, 2'b10, 16'hA5C3};
        issue(mk(1'b0, 5'h11, 5'h04, 16'hA5C3));
        check(reg_rdata[28] == 1'b1 && reg_rdata[27] == 1'b0, "R2 accept",
              64'(reg_rdata[28:27]), 64'b10);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        check((t1 - t0) == real'(2 * HALF * 10), "R8 mdc period",
              64'(int'(t1 - t0)), 64'(2 * HALF * 10));
        wait_idle();
        check(seen == exp, "R4 write frame", seen, exp);
        check(rise_n == 64 && oe_cnt == 64, "R4 write edges/drive",
              {32'(rise_n), 32'(oe_cnt)}, {32'd64, 32'd64});
        check(reg_rdata == mk(1'b0, 5'h11, 5'h04, 16'hA5C3), "R1 R9 write readback",
              64'(reg_rdata), 64'(mk(1'b0, 5'h11, 5'h04, 16'hA5C3)));
        check(!mdc && !mdio_oe, "R8 idle pins after frame", {mdc, mdio_oe}, 64'h0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] r);
        logic [45:0] exph;
        clear_phy();
        resp = r; ta_drv = 1'b0;
        exph = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra};
        issue(mk(1'b1, phy, ra, 16'h0));
        wait_idle();
        check(seen[63:18] == exph, "R5 read header", 64'(seen[63:18]), 64'(exph));
        check(oe_cnt == 46, "R5 release after header", 64'(oe_cnt), 64'd46);
        check(reg_rdata[27] == 1'b1, "R6 read valid", 64'(reg_rdata[27]), 64'd1);
        check(reg_rdata[15:0] == r, "R6 read data", 64'(reg_rdata[15:0]), 64'(r));
        check(reg_rdata[26:16] == {1'b1, ra, phy}, "R1 read fields",
              64'(reg_rdata[26:16]), 64'({1'b1, ra, phy}));
    endtask

    task automatic t_clear_valid();
        issue(mk(1'b0, 5'h02, 5'h09, 16'h1234));
        check(reg_rdata[28:27] == 2'b10, "R2 new command clears valid",
              64'(reg_rdata[28:27]), 64'b10);
        clear_phy();
        wait_idle();
        check(reg_rdata[27] == 1'b0, "R9 write ends without valid",
              64'(reg_rdata[27]), 64'd0);
    endtask

    task automatic t_bad_ta();
        clear_phy();
        resp = 16'h00FF; ta_drv = 1'b1;
        issue(mk(1'b1, 5'h07, 5'h01, 16'h0));
        wait_idle();
        check(reg_rdata[27] == 1'b0, "R7 bad turnaround", 64'(reg_rdata[27]), 64'd0);
        ta_drv = 1'b0;
    endtask

    task automatic t_busy_ignore();
        clear_phy();
        resp = 16'hC0DE; ta_drv = 1'b0;
        issue(mk(1'b1, 5'h03, 5'h07, 16'h0));
        repeat (10) @(negedge clk);
        issue(mk(1'b0, 5'h1F, 5'h1F, 16'h0000));
        check(reg_rdata[26:16] == {1'b1, 5'h07, 5'h03}, "R3 fields kept while busy",
              64'(reg_rdata[26:16]), 64'({1'b1, 5'h07, 5'h03}));
        wait_idle();
        repeat (300) @(negedge clk);
        check(rise_n == 64, "R3 no second frame", 64'(rise_n), 64'd64);
        check(reg_rdata[28:27] == 2'b01 && reg_rdata[15:0] == 16'hC0DE,
              "R3 first read completes", 64'(reg_rdata[28:0]),
              64'({2'b01, 1'b1, 5'h07, 5'h03, 16'hC0DE}));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        t_reset();
        t_write();
        t_read(5'h0A, 5'h15, 16'h3C5A);
        t_clear_valid();
        t_read(5'h00, 5'h00, 16'h8001);
        t_bad_ta();
        t_busy_ignore();
        summary();
    end
endmodule